// File: doc/BRIEF.md
# Three-Level Dyadic Wavelet Analysis Bank

This block splits a stream of signed 16-bit samples into four frequency bands. It does this with a three-stage tree of 4-tap low-pass and high-pass filters. Each stage keeps every second filter result. Its low-pass result is the input to the next stage, and its high-pass result leaves the block as a detail band. The low-pass result of the third stage leaves as the coarse approximation band. Samples and coefficients are signed fixed point with 14 fraction bits, so 16384 stands for 1.0.

Samples arrive on a valid/ready port and go into a small input store. When the store holds a full packet of four samples, the packet is copied to a working buffer. A single multiplier then walks each sample through the tree, one tap per clock. It forms the low-pass sum and then the high-pass sum for every stage that produces a result. Results leave on a shared data bus. A strobe vector has one bit per band, and a 2-bit tag names the band. The filter state of every stage carries over from one packet to the next, so the output is the same as a continuous convolution of the whole stream.

Top module: `dwt3_bank`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1, `band_vld` is 0, and all filter history and stage parity is zero.
- R2: The low-pass taps, newest sample first, are -2120, 3672, 13705 and 7913 (Q1.14). The low-pass result is y[n] = sum over k of g[k]·x[n-k].
- R3: The high-pass taps are the low-pass taps in reverse order with the sign alternating, starting negative: -7913, 13705, -3672, -2120.
- R4: Each product is rounded by adding 2^13 and shifting arithmetically right by 14, then clamped to [-32768, 32767]. The sum of the four rounded products is clamped to the same range.
- R5: Each stage emits a result only on the 2nd, 4th, 6th and later samples it receives since reset. N input samples give N/2 first-level details, N/4 second-level details, and N/8 (rounded down) of each third-level output.
- R6: The clamped low-pass result of stage 1 feeds stage 2, and that of stage 2 feeds stage 3. The third-stage approximation (tag 3) is emitted in the cycle right after the third-stage detail (tag 2).
- R7: Filter history is kept across packets. No stage restarts at a packet boundary.
- R8: The input store holds 12 samples. A packet of 4 is released only when at least 4 are held. Samples are filtered in arrival order.
- R9: `in_ready` is 0 from the cycle a packet is taken until its processing ends. No sample is accepted in that time.
- R10: Each result sets exactly one bit of `band_vld` for one cycle. The bit index equals `band_tag`: 0, 1 and 2 for the first, second and third detail bands, and 3 for the approximation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 16 | Signed Q1.14 input sample |
| in_ready | output | 1 | Block accepts a sample this cycle |
| band_vld | output | 4 | One strobe per band, one-hot when active |
| band_tag | output | 2 | Band number of the current result |
| band_data | output | 16 | Signed Q1.14 band result |

## Verification
The bench sweeps a single impulse across all eight positions of a three-stage decimation period, so impulses land both on and off every stage's keep phase. A design that kept the wrong parity, or that cleared history at packet edges, would put the response in the wrong outputs or lose part of it. Full-scale alternating samples drive the high-pass sum past the 16-bit range and catch a missing or misplaced clamp. A ramp and a DC level check the tap order and the mirrored high-pass signs, where a reversed or sign-swapped tap gives wrong values. The ready line is watched right after a packet is taken, and the band counts are checked at the end. Together these catch a block that accepts input while busy or that drops or repeats a result.

// File: rtl/dwt_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the wavelet analysis bank.
// Assumes: Q1.14 samples and coefficients, fixed 4-tap filters.
package dwt_pkg;
    localparam int SMP_W  = 16;
    localparam int FRAC_B = 14;
    localparam int NTAP   = 4;

    typedef logic signed [SMP_W-1:0] smp_t;

    // low-pass taps, index 0 applies to the newest sample
    localparam smp_t LP_TAP [NTAP] = '{-16'sd2120, 16'sd3672, 16'sd13705, 16'sd7913};

    // high-pass tap k: mirrored low-pass tap, negated on even k
    function automatic smp_t hp_tap(input int k);
        smp_t m;
        m = LP_TAP[NTAP-1-k];
        return (k % 2 == 0) ? -m : m;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_PUSH, ST_MAC, ST_EMIT, ST_APP
    } seq_st_e;
endpackage

// File: rtl/dwt_sample_store.sv
`timescale 1ns/1ps
// Circular sample store. It accepts one sample per write and shows the
// oldest PKT entries as a flat packet view. A release pulse drops them.
// Assumes: no write while a release is in progress; PKT <= DEPTH.
module dwt_sample_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 12,
    parameter int PKT   = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              rel,
    output logic [CW-1:0]     fill,
    output logic              pkt_ready,
    output logic              has_room,
    output logic [PKT*DW-1:0] pkt_view
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int d);
        int s;
        s = int'(p) + d;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    // storage write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_en) wptr <= wrap_add(wptr, 1);
            if (rel)   rptr <= wrap_add(rptr, PKT);
            cnt <= cnt + CW'(wr_en) - (rel ? CW'(PKT) : '0);
        end
    end

    for (genvar i = 0; i < PKT; i++) begin : g_view
        assign pkt_view[i*DW +: DW] = mem[wrap_add(rptr, i)];
    end

    assign fill      = cnt;
    assign pkt_ready = (cnt >= CW'(PKT));
    assign has_room  = (cnt < CW'(DEPTH));
endmodule

// File: rtl/dwt_tap_mac.sv
`timescale 1ns/1ps
// Shared multiply-accumulate. Each step multiplies one sample by one
// coefficient, rounds and clamps the product to DW bits, and adds it to
// the low-pass or the high-pass accumulator.
// Assumes: clr comes before each pair of sums; ACC_W > DW.
module dwt_tap_mac #(
    parameter int DW    = 16,
    parameter int FRAC  = 14,
    parameter int ACC_W = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic                 to_hp,
    input  logic signed [DW-1:0] smp,
    input  logic signed [DW-1:0] coef,
    output logic signed [DW-1:0] lp_out,
    output logic signed [DW-1:0] hp_out
);
    localparam int PW = 2 * DW;
    localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (FRAC - 1);
    localparam logic signed [PW-1:0] PMAX = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] PMIN = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] AMAX = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] AMIN = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    rnd;
    logic signed [PW-1:0]    shf;
    logic signed [DW-1:0]    term;
    logic signed [ACC_W-1:0] acc_lp;
    logic signed [ACC_W-1:0] acc_hp;

    assign prod = smp * coef;
    assign rnd  = prod + HALF;
    assign shf  = rnd >>> FRAC;

    // clamp the rounded product to the sample range
    always_comb begin
        if (shf > PMAX)      term = PMAX[DW-1:0];
        else if (shf < PMIN) term = PMIN[DW-1:0];
        else                 term = shf[DW-1:0];
    end

    // accumulate into the selected sum
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_lp <= '0;
            acc_hp <= '0;
        end else if (step) begin
            if (to_hp) acc_hp <= acc_hp + {{(ACC_W-DW){term[DW-1]}}, term};
            else       acc_lp <= acc_lp + {{(ACC_W-DW){term[DW-1]}}, term};
        end
    end

    // clamp the low-pass sum for output
    always_comb begin
        if (acc_lp > AMAX)      lp_out = AMAX[DW-1:0];
        else if (acc_lp < AMIN) lp_out = AMIN[DW-1:0];
        else                    lp_out = acc_lp[DW-1:0];
    end

    // clamp the high-pass sum for output
    always_comb begin
        if (acc_hp > AMAX)      hp_out = AMAX[DW-1:0];
        else if (acc_hp < AMIN) hp_out = AMIN[DW-1:0];
        else                    hp_out = acc_hp[DW-1:0];
    end
endmodule

// File: rtl/dwt_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencer for the stage tree. It takes a packet, then pushes each sample
// into stage 1. On every second push to a stage it runs 2*NTAP MAC steps
// (low-pass taps first, then high-pass) and emits the detail. It passes the
// approximation to the next stage, and on the last stage emits it too.
// Assumes: lp_res/hp_res are valid the cycle after the last MAC step.
module dwt_seq_ctrl
    import dwt_pkg::*;
#(
    parameter int DW     = SMP_W,
    parameter int PKT    = 4,
    parameter int LEVELS = 3,
    localparam int TAG_W = $clog2(LEVELS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_ready,
    input  logic [PKT*DW-1:0]    pkt_view,
    input  logic signed [DW-1:0] lp_res,
    input  logic signed [DW-1:0] hp_res,
    output logic                 rel,
    output logic                 busy,
    output logic                 mac_clr,
    output logic                 mac_step,
    output logic                 mac_hp,
    output logic signed [DW-1:0] mac_smp,
    output logic signed [DW-1:0] mac_coef,
    output logic [LEVELS:0]      band_vld,
    output logic [TAG_W-1:0]     band_tag,
    output logic signed [DW-1:0] band_data
);
    localparam int NB   = LEVELS + 1;
    localparam int LW   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int SW   = (PKT > 1) ? $clog2(PKT) : 1;
    localparam int NMAC = 2 * NTAP;
    localparam int TW   = $clog2(NMAC);
    localparam int KW   = $clog2(NTAP);

    seq_st_e               state;
    logic [SW-1:0]         smp_idx;
    logic [LW-1:0]         lvl;
    logic [TW-1:0]         tap;
    logic [KW-1:0]         tap_k;
    logic signed [DW-1:0]  carry;
    logic signed [DW-1:0]  pkt_q [PKT];
    logic signed [DW-1:0]  push_val;
    logic                  push_en;
    logic                  last_smp;
    logic signed [DW-1:0]  lvl_tap [LEVELS];
    logic [LEVELS-1:0]     lvl_odd;

    assign push_en  = (state == ST_PUSH);
    assign push_val = (lvl == '0) ? pkt_q[smp_idx] : carry;
    assign last_smp = (smp_idx == SW'(PKT - 1));
    assign tap_k    = tap[KW-1:0];

    // one delay line and keep-phase bit per stage
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        logic signed [DW-1:0] hq [NTAP];
        logic                 odd_q;

        // shift a new sample into this stage's delay line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < NTAP; k++) hq[k] <= '0;
                odd_q <= 1'b0;
            end else if (push_en && lvl == LW'(l)) begin
                hq[0] <= push_val;
                for (int k = 1; k < NTAP; k++) hq[k] <= hq[k-1];
                odd_q <= ~odd_q;
            end
        end

        assign lvl_tap[l] = hq[tap_k];
        assign lvl_odd[l] = odd_q;
    end

    // sequencing of packets, stages and tap steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            smp_idx   <= '0;
            lvl       <= '0;
            tap       <= '0;
            carry     <= '0;
            band_vld  <= '0;
            band_tag  <= '0;
            band_data <= '0;
            for (int i = 0; i < PKT; i++) pkt_q[i] <= '0;
        end else begin
            band_vld <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (pkt_ready) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    for (int i = 0; i < PKT; i++) pkt_q[i] <= pkt_view[i*DW +: DW];
                    smp_idx <= '0;
                    lvl     <= '0;
                    state   <= ST_PUSH;
                end
                ST_PUSH: begin
                    if (lvl_odd[lvl]) begin
                        tap   <= '0;
                        state <= ST_MAC;
                    end else if (last_smp) begin
                        state <= ST_IDLE;
                    end else begin
                        smp_idx <= smp_idx + 1'b1;
                        lvl     <= '0;
                        state   <= ST_PUSH;
                    end
                end
                ST_MAC: begin
                    tap <= tap + 1'b1;
                    if (tap == TW'(NMAC - 1)) state <= ST_EMIT;
                end
                ST_EMIT: begin
                    band_vld  <= NB'(1) << lvl;
                    band_tag  <= TAG_W'(lvl);
                    band_data <= hp_res;
                    if (lvl == LW'(LEVELS - 1)) begin
                        state <= ST_APP;
                    end else begin
                        carry <= lp_res;
                        lvl   <= lvl + 1'b1;
                        state <= ST_PUSH;
                    end
                end
                ST_APP: begin
                    band_vld  <= NB'(1) << LEVELS;
                    band_tag  <= TAG_W'(LEVELS);
                    band_data <= lp_res;
                    if (last_smp) begin
                        state <= ST_IDLE;
                    end else begin
                        smp_idx <= smp_idx + 1'b1;
                        lvl     <= '0;
                        state   <= ST_PUSH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // MAC operand selection and control strobes
    always_comb begin
        rel      = (state == ST_LOAD);
        busy     = (state != ST_IDLE);
        mac_clr  = push_en;
        mac_step = (state == ST_MAC);
        mac_hp   = tap[TW-1];
        mac_smp  = lvl_tap[lvl];
        mac_coef = mac_hp ? DW'(hp_tap(int'(tap_k))) : DW'(LP_TAP[tap_k]);
    end
endmodule

// File: rtl/dwt3_bank.sv
`timescale 1ns/1ps
// Three-stage wavelet analysis bank: input store, sequencer, shared MAC.
// Assumes: Q1.14 samples; results leave one per cycle at most on a shared
// bus, with a one-hot strobe and a band tag.
module dwt3_bank
    import dwt_pkg::*;
#(
    parameter int DW     = SMP_W,
    parameter int FRAC   = FRAC_B,
    parameter int DEPTH  = 12,
    parameter int PKT    = 4,
    parameter int LEVELS = 3,
    localparam int TAG_W = $clog2(LEVELS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 in_ready,
    output logic [LEVELS:0]      band_vld,
    output logic [TAG_W-1:0]     band_tag,
    output logic signed [DW-1:0] band_data
);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int ACC_W = DW + $clog2(NTAP) + 1;

    logic [CW-1:0]        fill_w;
    logic                 pkt_rdy_w;
    logic                 room_w;
    logic [PKT*DW-1:0]    view_w;
    logic                 rel_w;
    logic                 busy_w;
    logic                 wr_w;
    logic                 clr_w;
    logic                 step_w;
    logic                 hp_w;
    logic signed [DW-1:0] smp_w;
    logic signed [DW-1:0] coef_w;
    logic signed [DW-1:0] lp_w;
    logic signed [DW-1:0] hpres_w;

    assign in_ready = !busy_w && room_w;
    assign wr_w     = in_valid && in_ready;

    dwt_sample_store #(.DW(DW), .DEPTH(DEPTH), .PKT(PKT)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_w), .wr_data(in_data),
        .rel(rel_w), .fill(fill_w), .pkt_ready(pkt_rdy_w),
        .has_room(room_w), .pkt_view(view_w)
    );

    dwt_seq_ctrl #(.DW(DW), .PKT(PKT), .LEVELS(LEVELS)) seq_i (
        .clk(clk), .rst_n(rst_n), .pkt_ready(pkt_rdy_w), .pkt_view(view_w),
        .lp_res(lp_w), .hp_res(hpres_w), .rel(rel_w), .busy(busy_w),
        .mac_clr(clr_w), .mac_step(step_w), .mac_hp(hp_w),
        .mac_smp(smp_w), .mac_coef(coef_w),
        .band_vld(band_vld), .band_tag(band_tag), .band_data(band_data)
    );

    dwt_tap_mac #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W)) mac_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_w), .step(step_w), .to_hp(hp_w),
        .smp(smp_w), .coef(coef_w), .lp_out(lp_w), .hp_out(hpres_w)
    );
endmodule

// File: rtl/dwt3_bank_chk.sv
`timescale 1ns/1ps
// Protocol checker for dwt3_bank: store occupancy, packet release,
// input hold-off while busy, and output strobe and tag rules.
module dwt3_bank_chk #(
    parameter int DEPTH  = 12,
    parameter int PKT    = 4,
    parameter int LEVELS = 3,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int TAG_W = $clog2(LEVELS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rel,
    input logic [CW-1:0]    fill,
    input logic             pkt_ready,
    input logic [LEVELS:0]  band_vld,
    input logic [TAG_W-1:0] band_tag
);
    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));
    // R8
    pkt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> fill >= CW'(PKT));
    // R8
    pkt_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> fill == $past(fill) - CW'(PKT));
    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pkt_ready));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rel) |=> fill == $past(fill));
    // R10
    band_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(band_vld));
    // R10
    band_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (band_vld != '0) |-> band_vld[band_tag]);
    // R6
    app_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        band_vld[LEVELS] |-> $past(band_vld[LEVELS-1]));
endmodule

bind dwt3_bank dwt3_bank_chk #(.DEPTH(DEPTH), .PKT(PKT), .LEVELS(LEVELS)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .rel(rel_w), .fill(fill_w),
    .pkt_ready(pkt_rdy_w), .band_vld(band_vld), .band_tag(band_tag)
);

// File: tb/dwt3_bank_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: arithmetic model of the three-stage tree, pattern
// sweeps, per-band in-order comparison, hold-off and count checks.
module dwt3_bank_tb_top;
    localparam int LEVELS = 3;
    localparam int NB     = LEVELS + 1;
    localparam int QMAX   = 512;
    localparam int G [4]  = '{-2120, 3672, 13705, 7913};
    localparam int H [4]  = '{-7913, 13705, -3672, -2120};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               in_ready;
    logic [3:0]         band_vld;
    logic [1:0]         band_tag;
    logic signed [15:0] band_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_in = 0;
    int exp_mem [NB][QMAX];
    int exp_n [NB];
    int got_n [NB];
    int mh [LEVELS][4];
    bit modd [LEVELS];
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    dwt3_bank dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .band_vld(band_vld), .band_tag(band_tag),
        .band_data(band_data)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // R4: round half up at bit 13, shift by 14, clamp
    function automatic int rprod(int x, int c);
        return sat((x * c + 8192) >>> 14);
    endfunction

    task automatic push_exp(int b, int v);
        if (exp_n[b] < QMAX) exp_mem[b][exp_n[b]] = v;
        exp_n[b]++;
    endtask

    // R5 R6 R7: cascade with keep on every second push, history never cleared
    task automatic model_in(int x);
        int v;
        v = x;
        for (int l = 0; l < LEVELS; l++) begin
            bit was;
            int lp;
            int hp;
            was = modd[l];
            for (int k = 3; k > 0; k--) mh[l][k] = mh[l][k-1];
            mh[l][0] = v;
            modd[l] = !was;
            if (!was) break;
            lp = 0;
            hp = 0;
            for (int k = 0; k < 4; k++) begin
                lp += rprod(mh[l][k], G[k]);
                hp += rprod(mh[l][k], H[k]);
            end
            push_exp(l, sat(hp));
            if (l == LEVELS - 1) push_exp(LEVELS, sat(lp));
            v = sat(lp);
        end
    endtask

    // drive at negedge, hold until accepted, R8 keeps arrival order
    task automatic send(int x);
        in_data  = 16'(x);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        model_in(x);
        n_in++;
    endtask

    // compare every result in band order
    always @(negedge clk) begin
        if (rst_n && band_vld != '0) begin
            int t;
            int d;
            t = int'(band_tag);
            d = int'(band_data);
            chk("R10 strobe/tag", int'(band_vld), 1 << t);
            if (got_n[t] >= exp_n[t]) begin
                chk("R5 extra result", got_n[t] + 1, exp_n[t]);
            end else if (t == LEVELS) begin
                chk("R2 R6 app3 value", d, exp_mem[t][got_n[t]]);
            end else begin
                chk("R3 R4 detail value", d, exp_mem[t][got_n[t]]);
            end
            got_n[t]++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            exp_n[b] = 0;
            got_n[b] = 0;
        end
        for (int l = 0; l < LEVELS; l++) begin
            modd[l] = 1'b0;
            for (int k = 0; k < 4; k++) mh[l][k] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 ready after reset", int'(in_ready), 1);
        chk("R1 strobes after reset", int'(band_vld), 0);

        // R9: one packet, then ready must drop while it is processed
        send(16384); send(0); send(0); send(0);
        @(negedge clk);
        chk("R9 ready low while busy", int'(in_ready), 0);
        for (int i = 0; i < 400 && !in_ready; i++) @(negedge clk);
        chk("R9 ready back after packet", int'(in_ready), 1);
        chk("R5 det1 count after packet", got_n[0], 2);
        chk("R5 det2 count after packet", got_n[1], 1);

        // R7: impulse swept over all positions of the 8-sample period
        for (int p = 0; p < 8; p++)
            for (int i = 0; i < 16; i++)
                send(i == p ? ((p % 2 == 1) ? -32768 : 16384) : 0);

        // R2 R3: DC level
        for (int i = 0; i < 32; i++) send(9000);

        // R4: full-scale alternation overflows the high-pass sum
        for (int i = 0; i < 32; i++) send((i % 2 == 1) ? -32768 : 32767);

        // R2 R3: ramp checks tap order
        for (int i = 0; i < 32; i++) send(i * 1000 - 16000);

        // R8: pseudo-random stream with idle gaps
        for (int i = 0; i < 64; i++) begin
            lf = {1'b0, lf[15:1]} ^ (lf[0] ? 16'hB400 : 16'h0000);
            if (lf[3]) @(negedge clk);
            send(int'($signed(lf)));
        end

        for (int i = 0; i < 2000; i++) begin
            if (in_ready && got_n[0] == exp_n[0] && got_n[3] == exp_n[3]) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);

        // R5: band counts from the number of inputs
        chk("R5 det1 expected count", exp_n[0], n_in / 2);
        chk("R5 det2 expected count", exp_n[1], n_in / 4);
        chk("R5 det3 expected count", exp_n[2], n_in / 8);
        chk("R5 app3 expected count", exp_n[3], n_in / 8);
        for (int b = 0; b < NB; b++) chk("R5 R10 results per band", got_n[b], exp_n[b]);

        summary();
        $finish;
    end
endmodule